// File: doc/BRIEF.md
# Eight-State Compare-Select-Add Detector Core for an EPR4 Channel

This block runs the state-metric recursion of a maximum-likelihood sequence detector for a binary channel with the extended class-4 partial response target `1 + D - D^2 - D^3`. Input bits map to levels (bit 1 is +1, bit 0 is -1). Each equalized sample is one input to the recursion. The block computes the data-dependent branch terms from the samples itself. For every state it decides which of the two predecessor paths survives. It emits one survivor pointer per state, and an external traceback or register-exchange path memory consumes these pointers.

The recursion runs in the order compare, select, add rather than add, compare, select. The stored metric of each state already contains the part of the next branch metric that depends only on the predecessor. Because of this, the two paths entering a butterfly can be compared directly, with only a fixed offset between them. One difference per butterfly decides both successors. The add that follows the select applies a constant and one of four data-dependent terms. The data-dependent part of the stored metric needs the following sample, so the core works one sample behind its input.

A small controller has two states. `ST_PRIME` is entered at reset. The first valid sample moves it to `ST_RUN` (transition *prime*) and seeds the metrics. In `ST_RUN` each valid sample performs one recursion step (transition *step*, staying in `ST_RUN`). A cycle without a valid sample leaves both the state and the registers unchanged (transition *hold*, in either state). Reset returns the controller to `ST_PRIME`.

Top module: `epr4_csa_core`

## Requirements
- R1: While reset is asserted, and until the first valid sample after it, every state metric reads 0 and `ptr_vld` is 0.
- R2: The first valid sample after reset, y0, produces no pointer. In the next cycle the metric of each state with bit 0 clear reads +y0 and the metric of each state with bit 0 set reads -y0, both as METRIC_W-bit two's complement.
- R3: Every later valid sample performs exactly one recursion step. `ptr_vld` is 1 in the cycle after that sample and 0 in every other cycle.
- R4: In a cycle with `sample_vld` low, the metrics and pointers keep their values and `ptr_vld` is 0 in the following cycle.
- R5: The state index is {b(k-1), b(k-2), b(k-3)}, with the newest bit as the MSB. State s has the predecessors 2·(s mod 4), which is even, and 2·(s mod 4)+1, which is odd. Pointer bit s is 1 exactly when the odd predecessor survives.
- R6: Take a conventional model whose metrics M start at 0 when priming. At each step it adds the branch metric y·x - x²/2 to each candidate and keeps the larger, where x = a + a1 - a2 - a3 is built from the new bit and the three state bits. After k steps, with y' the most recent valid sample, each output metric equals M(s) - y'·a3(s) + k modulo 2^METRIC_W, where a3(s) is the level of state bit 0.
- R7: When the two candidates for a state are equal, the even predecessor survives and the pointer bit is 0.
- R8: For each butterfly j in 0..3, pointer bit j set implies pointer bit j+4 set, because both decisions come from one shared difference compared against two levels.
- R9: Metrics wrap modulo 2^METRIC_W and every comparison uses the sign of the wrapped difference, so R5 to R8 keep holding after the absolute metrics have passed the wrap point several times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_vld | input | 1 | The sample on `sample_in` is valid in this cycle |
| sample_in | input | SAMPLE_W | Equalized sample, two's complement |
| metric_out | output | 8·METRIC_W | Registered state metrics, state s in bits [s·METRIC_W +: METRIC_W] |
| ptr_out | output | 8 | Survivor pointers, bit s for state s |
| ptr_vld | output | 1 | `ptr_out` holds the decisions of a new step |

## Verification
The bench builds the core with its defaults, a 6-bit sample and a 10-bit metric. These are narrow enough that a run of about nine hundred noiseless steps carries the absolute metrics past the 10-bit wrap point more than twice, while the spread between states stays well inside half the range. Noiseless, noisy and all-zero sample streams drive the butterflies through every survivor combination and through equal-candidate ties. Idle gaps, reset in the middle of a run and priming with negative samples exercise each transition of the controller.

// File: rtl/epr4_csa_pkg.sv
package epr4_csa_pkg;

    localparam int NUM_STATES = 8;
    localparam int NUM_BFLY   = NUM_STATES / 2;

    typedef enum logic [0:0] {
        ST_PRIME = 1'b0,
        ST_RUN   = 1'b1
    } det_state_e;

    // Level (+1 or -1) of bit 'pos' of state index 's'.
    function automatic int level_of(input int s, input int pos);
        return (((s >> pos) & 1) == 1) ? 1 : -1;
    endfunction

    // Sum of the three newest levels that a successor state fixes:
    // u = a + a1 - a2, with a = bit 2, a1 = bit 1, a2 = bit 0.
    function automatic int u_of(input int s);
        return level_of(s, 2) + level_of(s, 1) - level_of(s, 0);
    endfunction

    // Constant that follows the select: -u - (u*u - 1)/2.
    function automatic int post_off(input int s);
        int u;
        u = u_of(s);
        return -u - (((u == 3) || (u == -3)) ? 4 : 0);
    endfunction

endpackage

// File: rtl/epr4_bmu.sv
// Branch-term unit: four data-dependent sums, each used with both signs.
module epr4_bmu #(
    parameter int SAMPLE_W = 6,
    parameter int METRIC_W = 10
) (
    input  logic signed [SAMPLE_W-1:0] y_cur,
    input  logic signed [SAMPLE_W-1:0] y_nxt,
    output logic        [METRIC_W-1:0] term [8]
);

    localparam int EXT_W = SAMPLE_W + 3;

    logic signed [EXT_W-1:0] yc;
    logic signed [EXT_W-1:0] yn;
    logic signed [EXT_W-1:0] yc3;

    assign yc  = EXT_W'(y_cur);
    assign yn  = EXT_W'(y_nxt);
    assign yc3 = yc + (yc <<< 1);

    // Term for successor s: y_cur*u(s) - y_nxt*a2(s).
    // States 4+k and 3-k are bitwise complements, so their terms differ in sign.
    for (genvar k = 0; k < 4; k++) begin : g_term
        localparam int SUCC = 4 + k;
        localparam int U    = epr4_csa_pkg::u_of(SUCC);
        localparam int A2   = epr4_csa_pkg::level_of(SUCC, 0);

        logic signed [EXT_W-1:0] ypart;
        logic signed [EXT_W-1:0] dsum;
        logic signed [METRIC_W-1:0] dwide;

        if (U == 3) begin : g_u3
            assign ypart = yc3;
        end else if (U == 1) begin : g_u1
            assign ypart = yc;
        end else begin : g_un
            assign ypart = -yc;
        end

        if (A2 > 0) begin : g_sub
            assign dsum = ypart - yn;
        end else begin : g_add
            assign dsum = ypart + yn;
        end

        assign dwide       = METRIC_W'(dsum);
        assign term[SUCC]  = dwide;
        assign term[3 - k] = -dwide;
    end

endmodule

// File: rtl/epr4_cs2.sv
// Two-level compare-select: one shared difference, two thresholds.
module epr4_cs2 #(
    parameter int METRIC_W = 10,
    parameter int OFF_LO   = 0,
    parameter int OFF_HI   = 4
) (
    input  logic [METRIC_W-1:0] w_even,
    input  logic [METRIC_W-1:0] w_odd,
    output logic [METRIC_W-1:0] sel_lo,
    output logic [METRIC_W-1:0] sel_hi,
    output logic                dec_lo,
    output logic                dec_hi
);

    localparam logic [METRIC_W-1:0] K_LO = METRIC_W'(OFF_LO);
    localparam logic [METRIC_W-1:0] K_HI = METRIC_W'(OFF_HI);

    logic [METRIC_W-1:0] gap;
    logic [METRIC_W-1:0] d_lo;
    logic [METRIC_W-1:0] d_hi;

    always_comb begin
        gap    = w_odd - w_even;
        d_lo   = gap + K_LO;
        d_hi   = gap + K_HI;
        // Odd survives only when strictly larger (wrapped sign test).
        dec_lo = !d_lo[METRIC_W-1] && (d_lo != '0);
        dec_hi = !d_hi[METRIC_W-1] && (d_hi != '0);
        sel_lo = dec_lo ? (w_odd + K_LO) : w_even;
        sel_hi = dec_hi ? (w_odd + K_HI) : w_even;
    end

endmodule

// File: rtl/epr4_upd.sv
// Post-select add: constant offset plus one data-dependent term.
module epr4_upd #(
    parameter int METRIC_W = 10,
    parameter int POST_OFF = 0
) (
    input  logic [METRIC_W-1:0] sel,
    input  logic [METRIC_W-1:0] term,
    output logic [METRIC_W-1:0] w_nxt
);

    localparam logic [METRIC_W-1:0] K_POST = METRIC_W'(POST_OFF);

    assign w_nxt = sel + term + K_POST;

endmodule

// File: rtl/epr4_csa_core.sv
module epr4_csa_core
    import epr4_csa_pkg::*;
#(
    parameter int SAMPLE_W = 6,
    parameter int METRIC_W = 10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sample_vld,
    input  logic [SAMPLE_W-1:0]            sample_in,
    output logic [NUM_STATES*METRIC_W-1:0] metric_out,
    output logic [NUM_STATES-1:0]          ptr_out,
    output logic                           ptr_vld
);

    det_state_e state_q;
    det_state_e state_d;

    logic [SAMPLE_W-1:0]   y_hold_q;
    logic [METRIC_W-1:0]   w_q    [NUM_STATES];
    logic [METRIC_W-1:0]   w_new  [NUM_STATES];
    logic [METRIC_W-1:0]   w_init [NUM_STATES];
    logic [METRIC_W-1:0]   sel    [NUM_STATES];
    logic [METRIC_W-1:0]   term   [NUM_STATES];
    logic [NUM_STATES-1:0] dec;
    logic [NUM_STATES-1:0] ptr_q;
    logic                  vld_q;
    logic [METRIC_W-1:0]   y_ext;

    // Controller: state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PRIME;
        else        state_q <= state_d;
    end

    // Controller: next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: if (sample_vld) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
        endcase
    end

    // Branch terms: recursion step uses held sample and the new one.
    epr4_bmu #(
        .SAMPLE_W(SAMPLE_W),
        .METRIC_W(METRIC_W)
    ) u_bmu (
        .y_cur(y_hold_q),
        .y_nxt(sample_in),
        .term (term)
    );

    // Four butterflies: predecessors 2j and 2j+1, successors j and j+4.
    for (genvar j = 0; j < NUM_BFLY; j++) begin : g_bfly
        epr4_cs2 #(
            .METRIC_W(METRIC_W),
            .OFF_LO  (2 * u_of(j)),
            .OFF_HI  (2 * u_of(j + NUM_BFLY))
        ) u_cs (
            .w_even(w_q[2*j]),
            .w_odd (w_q[2*j+1]),
            .sel_lo(sel[j]),
            .sel_hi(sel[j+NUM_BFLY]),
            .dec_lo(dec[j]),
            .dec_hi(dec[j+NUM_BFLY])
        );
    end

    for (genvar s = 0; s < NUM_STATES; s++) begin : g_upd
        epr4_upd #(
            .METRIC_W(METRIC_W),
            .POST_OFF(post_off(s))
        ) u_upd (
            .sel  (sel[s]),
            .term (term[s]),
            .w_nxt(w_new[s])
        );
    end

    // Seed values: predecessor-only part of the first branch metric.
    assign y_ext = METRIC_W'($signed(sample_in));
    for (genvar s = 0; s < NUM_STATES; s++) begin : g_init
        if ((s % 2) == 0) begin : g_even
            assign w_init[s] = y_ext;
        end else begin : g_odd
            assign w_init[s] = -y_ext;
        end
    end

    // Output process: datapath registers driven per controller state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_STATES; s++) w_q[s] <= '0;
            ptr_q    <= '0;
            vld_q    <= 1'b0;
            y_hold_q <= '0;
        end else begin
            vld_q <= 1'b0;
            unique case (state_q)
                ST_PRIME: begin
                    if (sample_vld) begin
                        for (int s = 0; s < NUM_STATES; s++) w_q[s] <= w_init[s];
                        y_hold_q <= sample_in;
                    end
                end
                ST_RUN: begin
                    if (sample_vld) begin
                        for (int s = 0; s < NUM_STATES; s++) w_q[s] <= w_new[s];
                        ptr_q    <= dec;
                        vld_q    <= 1'b1;
                        y_hold_q <= sample_in;
                    end
                end
            endcase
        end
    end

    for (genvar s = 0; s < NUM_STATES; s++) begin : g_out
        assign metric_out[s*METRIC_W +: METRIC_W] = w_q[s];
    end
    assign ptr_out = ptr_q;
    assign ptr_vld = vld_q;

endmodule

// File: rtl/epr4_csa_chk.sv
module epr4_csa_chk #(
    parameter int METRIC_W = 10
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sample_vld,
    input logic [8*METRIC_W-1:0] metric_out,
    input logic [7:0]            ptr_out,
    input logic                  ptr_vld
);

    logic [METRIC_W-1:0] m [8];
    logic                prime_shape;

    for (genvar s = 0; s < 8; s++) begin : g_m
        assign m[s] = metric_out[s*METRIC_W +: METRIC_W];
    end

    always_comb begin
        prime_shape = 1'b1;
        for (int s = 1; s < 8; s++) begin
            if ((s % 2) == 0) begin
                if (m[s] != m[0]) prime_shape = 1'b0;
            end else begin
                if (METRIC_W'(m[s] + m[0]) != '0) prime_shape = 1'b0;
            end
        end
    end

    // R1: registers cleared while reset is held.
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_clear_r1: assert (ptr_vld == 1'b0 && metric_out == '0)
                else $error("reset state not clear");
        end
    end

    // R2: a priming cycle leaves the +y0 / -y0 pattern.
    p_prime_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sample_vld) && !ptr_vld) |-> prime_shape);

    // R3: a pointer is only offered after a valid sample.
    p_ptr_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_vld |-> $past(sample_vld));

    // R4: idle cycles hold the metrics and withhold pointers.
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> ($stable(metric_out) && !ptr_vld));

    // R8: lower successor choosing odd forces upper successor odd.
    p_pair_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_vld |-> ((ptr_out[3:0] & ~ptr_out[7:4]) == 4'b0000));

endmodule

bind epr4_csa_core epr4_csa_chk #(.METRIC_W(METRIC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_vld(sample_vld),
    .metric_out(metric_out),
    .ptr_out   (ptr_out),
    .ptr_vld   (ptr_vld)
);

// File: tb/tb_epr4_csa_core.sv
module tb_epr4_csa_core;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 6;
    localparam int MW = 10;
    localparam int NS = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b1;
    logic              sample_vld = 1'b0;
    logic [SW-1:0]     sample_in = '0;
    logic [NS*MW-1:0]  metric_out;
    logic [NS-1:0]     ptr_out;
    logic              ptr_vld;

    int     n_checks = 0;
    int     n_fail   = 0;
    longint m [NS];
    longint k_steps;
    int     y_prev;
    logic [2:0] hist = 3'b000;
    longint base_m0;

    always #(CLK_PERIOD/2) clk = ~clk;

    epr4_csa_core #(.SAMPLE_W(SW), .METRIC_W(MW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_vld(sample_vld),
        .sample_in (sample_in),
        .metric_out(metric_out),
        .ptr_out   (ptr_out),
        .ptr_vld   (ptr_vld)
    );

    function automatic int lv(input int s, input int pos);
        return (((s >> pos) & 1) == 1) ? 1 : -1;
    endfunction

    function automatic longint mo(input int s);
        return longint'(metric_out[s*MW +: MW]);
    endfunction

    function automatic longint wrap(input longint v);
        longint r;
        r = v % (64'sd1 << MW);
        if (r < 0) r = r + (64'sd1 << MW);
        return r;
    endfunction

    task automatic check(input string req, input string what, input longint got, input longint exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // R6: absolute metric relation to the conventional model.
    task automatic check_metrics(input string req, input int ynext);
        for (int s = 0; s < NS; s++)
            check(req, $sformatf("metric[%0d]", s), mo(s),
                  wrap(m[s] - longint'(ynext * lv(s, 0)) + k_steps));
    endtask

    task automatic do_reset();
        @(negedge clk);
        sample_vld = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        for (int s = 0; s < NS; s++) check("R1", "metric in reset", mo(s), 0);
        check("R1", "ptr_vld in reset", longint'(ptr_vld), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ptr_vld after reset", longint'(ptr_vld), 0);
        for (int s = 0; s < NS; s++) check("R1", "metric after reset", mo(s), 0);
        hist = 3'b000;
    endtask

    // Called at a negedge; returns at the negedge after the update.
    task automatic prime(input int y0);
        sample_vld = 1'b1;
        sample_in  = y0[SW-1:0];
        @(negedge clk);
        sample_vld = 1'b0;
        for (int s = 0; s < NS; s++) m[s] = 0;
        k_steps = 0;
        y_prev  = y0;
        check("R2", "ptr_vld on prime", longint'(ptr_vld), 0);
        for (int s = 0; s < NS; s++)
            check("R2", $sformatf("seed metric[%0d]", s), mo(s),
                  wrap((s % 2 == 0) ? y0 : -y0));
    endtask

    task automatic step(input int y);
        longint   mn [NS];
        logic [NS-1:0] ep;
        sample_vld = 1'b1;
        sample_in  = y[SW-1:0];
        @(negedge clk);
        sample_vld = 1'b0;
        for (int sp = 0; sp < NS; sp++) begin
            int u, p0, x0, x1;
            longint c0, c1;
            u  = lv(sp, 2) + lv(sp, 1) - lv(sp, 0);
            p0 = (sp % 4) * 2;
            x0 = u + 1;
            x1 = u - 1;
            c0 = m[p0]     + longint'(y_prev * x0 - (x0 * x0) / 2);
            c1 = m[p0 + 1] + longint'(y_prev * x1 - (x1 * x1) / 2);
            ep[sp] = (c1 > c0);
            mn[sp] = (c1 > c0) ? c1 : c0;
        end
        for (int s = 0; s < NS; s++) m[s] = mn[s];
        k_steps++;
        y_prev = y;
        check("R3", "ptr_vld after step", longint'(ptr_vld), 1);
        check("R5", "ptr_out", longint'(ptr_out), longint'(ep));
        check("R8", "pair order", longint'(ptr_out[3:0] & ~ptr_out[7:4]), 0);
        check_metrics("R6", y);
    endtask

    task automatic idle(input int n);
        logic [NS*MW-1:0] snap;
        logic [NS-1:0]    psnap;
        snap  = metric_out;
        psnap = ptr_out;
        repeat (n) @(negedge clk);
        check("R4", "metrics held", longint'(metric_out != snap), 0);
        check("R4", "ptr held", longint'(ptr_out), longint'(psnap));
        check("R3", "ptr_vld low when idle", longint'(ptr_vld), 0);
    endtask

    // Channel sample from a fresh random bit plus noise in [-amp, amp].
    task automatic channel_run(input int n, input int amp, input int gap_every);
        for (int i = 0; i < n; i++) begin
            logic b;
            int x, y;
            b = 1'($urandom);
            x = (b ? 1 : -1) + (hist[2] ? 1 : -1) - (hist[1] ? 1 : -1) - (hist[0] ? 1 : -1);
            y = x;
            if (amp > 0) y = x + int'($urandom_range(0, 2 * amp)) - amp;
            hist = {b, hist[2:1]};
            step(y);
            if (gap_every > 0 && (i % gap_every) == gap_every - 1) idle(1);
        end
    endtask

    task automatic t_reset_and_idle();
        do_reset();
        idle(3);
        for (int s = 0; s < NS; s++) check("R1", "idle before prime", mo(s), 0);
    endtask

    task automatic t_prime_and_gap();
        prime(5);
        idle(4);
        check_metrics("R4", y_prev);
    endtask

    task automatic t_clean();
        channel_run(40, 0, 0);
    endtask

    task automatic t_noisy();
        channel_run(300, 2, 7);
    endtask

    task automatic t_zero_ties();
        // All-zero samples: equal candidates appear, even predecessor wins (R7).
        for (int i = 0; i < 20; i++) step(0);
        check_metrics("R7", 0);
    endtask

    task automatic t_wrap();
        base_m0 = m[0] + k_steps;
        channel_run(900, 0, 0);
        check("R9", "metric growth beyond two wraps",
              longint'((m[0] + k_steps - base_m0) >= (64'sd2 << MW)), 1);
    endtask

    task automatic t_reprime();
        channel_run(10, 1, 0);
        do_reset();
        prime(-7);
        channel_run(30, 1, 5);
        do_reset();
        prime(-32);
        channel_run(20, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        #1 rst_n = 1'b0;
        t_reset_and_idle();
        t_prime_and_gap();
        t_clean();
        t_noisy();
        t_zero_ties();
        t_wrap();
        t_reprime();
        summary();
        $finish;
    end

endmodule